// File: doc/BRIEF.md
# Programmable Bus Waveform Sequencer

This block generates the control-line waveforms for an external memory bus from a small, host-loaded pattern memory. Each bus cycle takes four clocks, the quarter phases T1, T2, T3 and T4. Every stored 32-bit microword gives each of four control lines one level for the first half of the cycle (T1 and T2) and one for the second half (T3 and T4). The sequencer consumes one microword per bus cycle, starting at a host-chosen address. It stops after a word flagged as last, and all lines then rest at logic 1.

A static mode input decides the role of the fourth line. In output mode it is driven like the other three. In wait mode the pin is treated as a wait input, and the line's two microword bits take other jobs. One chooses the quarter phase at which a one-clock read-data sample strobe fires. The other enables a freeze: while the synchronized wait input is high, the phase and the word address hold, so every output level stays where it is.

The host loads the pattern memory while the sequencer is idle. It then pulses the start input with a start address and a read flag.

Top module: `wave_seq`

## Requirements
- R1: After reset, all four control lines are 1, the sample strobe is 0 and the sequencer is idle.
- R2: A host write changes the pattern memory only while the sequencer is idle. A write presented while it is running is ignored.
- R3: A start seen while idle begins at start_addr in quarter phase T1 on the clock after the start edge. Line n (ctl_out[n-1]) takes microword bit 12+2(n-1) during T1 and T2, and bit 13+2(n-1) during T3 and T4. This holds for lines 1 to 3, and for line 4 in output mode (mode input 0).
- R4: Each microword lasts exactly four clocks, and the next word is taken from address+1, wrapping from the top address to 0. After a word with bit 31 set completes, the sequencer goes idle and all lines read 1 on the following clock.
- R5: In wait mode (mode input 1), ctl_out[3] stays at 1, and bits 18 and 19 have no effect on any line level.
- R6: The sample strobe is high for exactly one clock per microword, and only when the start marked the access as a read. It fires in T1 in output mode. In wait mode it fires in T1 when bit 18 is 0 and in T3 when bit 18 is 1.
- R7: In wait mode, with bit 19 of the current word set, a wait input high for two clocks (two-flop synchronizer) freezes phase, address and all outputs. The strobe is suppressed until the synchronized wait falls, after which the sequence resumes where it stopped.
- R8: The wait input has no effect when bit 19 of the current word is 0 or when the mode input is 0.
- R9: A start presented while the sequencer is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the bus rate |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Pattern memory write enable |
| host_addr | input | ADDR_W | Pattern memory write address |
| host_wdata | input | WORD_W | Microword to write |
| start | input | 1 | Start pulse, taken only while idle |
| start_addr | input | ADDR_W | First microword address |
| start_read | input | 1 | Marks the access as a read (enables the strobe) |
| wait_mode | input | 1 | 0: line 4 is an output; 1: line 4 is a wait input |
| wait_in | input | 1 | Asynchronous wait request |
| ctl_out | output | 4 | Control lines 1 to 4 in bits 0 to 3 |
| sample_stb | output | 1 | One-clock read-data sample strobe |

## Verification
The bench builds the block with its default parameters: a 6-bit address (64 words) and a two-stage wait synchronizer. With the full address range in place, a two-word program starting at the top address shows the wrap to address 0 between words. The two-stage synchronizer lets the freeze test predict exactly which clock the strobe returns on after wait falls. Table-driven single-word runs cover both line-4 modes and both sample points. Directed runs cover writes and starts arriving mid-sequence and wait levels that must be ignored.

// File: rtl/wseq_pkg.sv
// Shared constants for the waveform sequencer: microword bit positions
// and line count. Assumes a 32-bit microword.
package wseq_pkg;
    localparam int NUM_LINES = 4;
    localparam int LVL_LO    = 12;  // first level bit (line 1, first half)
    localparam int SDLY_BIT  = 18;  // sample point select in wait mode
    localparam int WEN_BIT   = 19;  // freeze enable in wait mode
    localparam int LAST_BIT  = 31;  // end-of-program marker
    localparam int FIELD_W   = 2 * NUM_LINES;
endpackage

// File: rtl/wseq_sync.sv
// Multi-flop synchronizer for the asynchronous wait request.
// Assumes STAGES >= 1; output lags the input by STAGES clocks.
module wseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // shift the request one flop further per clock
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= 1'b0;
                else if (s == 0) chain[s] <= d_in;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/wseq_store.sv
// Pattern memory: one write port gated by the busy flag, one
// combinational read port. Contents are not reset; the host loads them.
module wseq_store #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic              busy,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // accept host writes only while the sequencer is idle
    always_ff @(posedge clk) begin
        if (we && !busy) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/wseq_ctrl.sv
// Phase counter and word-address sequencer. One microword per four
// phases; halts on the last-word flag; holds while frozen by wait.
module wseq_ctrl #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              start_read,
    input  logic              word_last,
    input  logic              word_wen,
    input  logic              wait_mode,
    input  logic              wait_s,
    output logic              active,
    output logic [1:0]        ph,
    output logic [ADDR_W-1:0] addr,
    output logic              rd,
    output logic              frozen
);
    // freeze only when the line is a wait input and the word allows it
    assign frozen = active && wait_mode && word_wen && wait_s;

    // advance phase and address, launch on start, stop after last word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            ph     <= 2'd0;
            addr   <= '0;
            rd     <= 1'b0;
        end else if (!active) begin
            if (start) begin
                active <= 1'b1;
                addr   <= start_addr;
                ph     <= 2'd0;
                rd     <= start_read;
            end
        end else if (!frozen) begin
            ph <= ph + 2'd1;
            if (ph == 2'd3) begin
                if (word_last) active <= 1'b0;
                else addr <= addr + 1'b1;
            end
        end
    end

    assert_freeze_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> (active && ph == $past(ph) && addr == $past(addr)));

    assert_phase_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !frozen) |=> (ph == $past(ph) + 2'd1));

    assert_last_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !frozen && ph == 2'd3 && word_last) |=> !active);

    assert_start_busy_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && start && ph != 2'd3) |=> (active && addr == $past(addr)));
endmodule

// File: rtl/wseq_decode.sv
// Output decode: picks first-half or second-half levels per line,
// forces idle lines high, and places the read sample strobe.
module wseq_decode
    import wseq_pkg::*;
(
    input  logic               active,
    input  logic [1:0]         ph,
    input  logic [FIELD_W-1:0] field,
    input  logic               rd,
    input  logic               wait_mode,
    input  logic               frozen,
    output logic [NUM_LINES-1:0] ctl_out,
    output logic               sample_stb
);
    logic [NUM_LINES-1:0] first_half, second_half;
    logic [1:0]           stb_ph;

    // split the even/odd level bits into per-half line vectors
    always_comb begin
        for (int n = 0; n < NUM_LINES; n++) begin
            first_half[n]  = field[2*n];
            second_half[n] = field[2*n+1];
        end
        if (wait_mode) begin
            first_half[NUM_LINES-1]  = 1'b1;
            second_half[NUM_LINES-1] = 1'b1;
        end
    end

    // select the half by phase; idle lines rest high
    assign ctl_out = !active ? '1 : (ph[1] ? second_half : first_half);

    // sample point: T3 only when wait mode selects the late point
    assign stb_ph     = (wait_mode && field[SDLY_BIT-LVL_LO]) ? 2'd2 : 2'd0;
    assign sample_stb = active && rd && !frozen && (ph == stb_ph);
endmodule

// File: rtl/wave_seq.sv
// Top of the programmable bus waveform sequencer. Ties the pattern
// memory, wait synchronizer, sequencer and output decode together.
// Assumes wait_mode is static while a program runs.
module wave_seq
    import wseq_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int WORD_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              start_read,
    input  logic              wait_mode,
    input  logic              wait_in,
    output logic [3:0]        ctl_out,
    output logic              sample_stb
);
    logic [WORD_W-1:0] word;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        ph;
    logic              active, rd, frozen, wait_s;
    logic              unused_word_bits;

    assign unused_word_bits = ^{word[WORD_W-1:LVL_LO+FIELD_W], word[LVL_LO-1:0]};

    wseq_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_in(wait_in), .d_out(wait_s)
    );

    wseq_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) store_i (
        .clk(clk), .we(host_we), .busy(active), .waddr(host_addr),
        .wdata(host_wdata), .raddr(addr), .rdata(word)
    );

    wseq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .start_read(start_read), .word_last(word[LAST_BIT]),
        .word_wen(word[WEN_BIT]), .wait_mode(wait_mode), .wait_s(wait_s),
        .active(active), .ph(ph), .addr(addr), .rd(rd), .frozen(frozen)
    );

    wseq_decode decode_i (
        .active(active), .ph(ph), .field(word[LVL_LO+FIELD_W-1:LVL_LO]),
        .rd(rd), .wait_mode(wait_mode), .frozen(frozen),
        .ctl_out(ctl_out), .sample_stb(sample_stb)
    );

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);
endmodule

// File: tb/wave_seq_tb_top.sv
// Self-checking bench for wave_seq: table-driven single-word runs,
// then directed tests for reset, wrap, busy writes/starts and wait.
module wave_seq_tb_top;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        host_we = 1'b0, start = 1'b0, start_read = 1'b0;
    logic [5:0]  host_addr = '0, start_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        wait_mode = 1'b0, wait_in = 1'b0;
    logic [3:0]  ctl_out;
    logic        sample_stb;
    int          n_chk = 0, n_err = 0, cyc = 0;

    always #10 clk = ~clk;

    wave_seq dut_i (.*);

    // entry: {field[7:0], mode, read, t1[3:0], t3[3:0], strobe phase (4 = none)}
    localparam logic [20:0] VEC [0:6] = '{
        {8'h00, 1'b0, 1'b0, 4'h0, 4'h0, 3'd4},
        {8'h55, 1'b0, 1'b1, 4'hF, 4'h0, 3'd0},
        {8'hAA, 1'b0, 1'b0, 4'h0, 4'hF, 3'd4},
        {8'h49, 1'b1, 1'b1, 4'h9, 4'hA, 3'd2},
        {8'h06, 1'b1, 1'b1, 4'hA, 4'h9, 3'd0},
        {8'h80, 1'b1, 1'b0, 4'h8, 4'h8, 3'd4},
        {8'h30, 1'b0, 1'b1, 4'h4, 4'h4, 3'd0}
    };

    function automatic logic [31:0] mkword(input logic last, input logic [7:0] f);
        return {last, 11'd0, f, 12'd0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk); host_we = 1'b0;
    endtask

    task automatic pulse_start(input logic [5:0] a, input logic rd);
        @(negedge clk); start = 1'b1; start_addr = a; start_read = rd;
        @(negedge clk); start = 1'b0;
    endtask

    // checks the four phases of one word; ends in that word's T4
    task automatic chk_word(input string req, input logic [3:0] t1, input logic [3:0] t3,
                            input logic [2:0] sp);
        for (int p = 0; p < 4; p++) begin
            if (p > 0) @(negedge clk);
            chk({req, " level"}, {28'd0, ctl_out}, {28'd0, (p < 2) ? t1 : t3});
            chk({req, " strobe R6"}, {31'd0, sample_stb}, {31'd0, (p == int'(sp))});
        end
    endtask

    task automatic chk_idle(input string req);
        @(negedge clk);
        chk({req, " idle lines"}, {28'd0, ctl_out}, 32'hF);
        chk({req, " idle strobe"}, {31'd0, sample_stb}, 32'd0);
    endtask

    // watchdog: a hung run counts as one failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        chk("R1 lines", {28'd0, ctl_out}, 32'hF);
        chk("R1 strobe", {31'd0, sample_stb}, 32'd0);

        // table: single last-flagged words at address 5 (R3, R5, R6)
        foreach (VEC[i]) begin
            wait_mode = VEC[i][12];
            hwrite(6'd5, mkword(1'b1, VEC[i][20:13]));
            pulse_start(6'd5, VEC[i][11]);
            chk_word("R3/R5", VEC[i][10:7], VEC[i][6:3], VEC[i][2:0]);
            chk_idle("R4");
        end

        // R4: two-word program wrapping from address 63 to 0
        wait_mode = 1'b0;
        hwrite(6'd63, mkword(1'b0, 8'h55));
        hwrite(6'd0,  mkword(1'b1, 8'hAA));
        pulse_start(6'd63, 1'b0);
        chk_word("R4 word0", 4'hF, 4'h0, 3'd4);
        @(negedge clk);
        chk_word("R4 word1 wrap", 4'h0, 4'hF, 3'd4);
        chk_idle("R4 end");

        // R2: write while running is ignored
        hwrite(6'd10, mkword(1'b1, 8'h00));
        hwrite(6'd11, mkword(1'b1, 8'h00));
        pulse_start(6'd10, 1'b0);
        host_we = 1'b1; host_addr = 6'd11; host_wdata = mkword(1'b1, 8'hFF);
        @(negedge clk); host_we = 1'b0;
        @(negedge clk); @(negedge clk);
        chk_idle("R2 run end");
        pulse_start(6'd11, 1'b0);
        chk_word("R2 old content kept", 4'h0, 4'h0, 3'd4);
        chk_idle("R2");

        // R9: start while running is ignored
        hwrite(6'd20, mkword(1'b1, 8'hFF));
        pulse_start(6'd10, 1'b0);
        start = 1'b1; start_addr = 6'd20;
        @(negedge clk); start = 1'b0;
        chk("R9 level unchanged", {28'd0, ctl_out}, 32'h0);
        @(negedge clk); @(negedge clk);
        chk_idle("R9 no restart");
        chk_idle("R9 stays idle");

        // R7: freeze with wait held, then release
        wait_mode = 1'b1; wait_in = 1'b1;
        hwrite(6'd30, mkword(1'b1, 8'h81));
        pulse_start(6'd30, 1'b1);
        for (int k = 0; k < 10; k++) begin
            chk("R7 frozen level", {28'd0, ctl_out}, 32'h9);
            chk("R7 strobe held off", {31'd0, sample_stb}, 32'd0);
            @(negedge clk);
        end
        wait_in = 1'b0;
        @(negedge clk);
        chk("R7 sync delay", {31'd0, sample_stb}, 32'd0);
        @(negedge clk);
        chk("R7 resume strobe", {31'd0, sample_stb}, 32'd1);
        chk("R7 resume level", {28'd0, ctl_out}, 32'h9);
        @(negedge clk);
        chk("R7 T2", {31'd0, sample_stb}, 32'd0);
        @(negedge clk);
        chk("R7 T3 level", {28'd0, ctl_out}, 32'h8);
        @(negedge clk);
        chk_idle("R7 end");

        // R8: wait ignored when bit 19 is 0, and in output mode
        wait_in = 1'b1;
        hwrite(6'd31, mkword(1'b1, 8'h01));
        repeat (3) @(negedge clk);
        pulse_start(6'd31, 1'b1);
        chk_word("R8 wen=0", 4'h9, 4'h8, 3'd0);
        chk_idle("R8 wen=0");
        wait_mode = 1'b0;
        hwrite(6'd32, mkword(1'b1, 8'h80));
        pulse_start(6'd32, 1'b0);
        chk_word("R8 output mode", 4'h0, 4'h8, 3'd4);
        chk_idle("R8 output mode");
        wait_in = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule